// File: doc/BRIEF.md
# Vectored Interrupt Controller with Mask

This block gathers level-sensitive interrupt lines from peripherals into a pending word, gates that word with a software-owned enable mask, and turns the result into a request wire plus an 8-bit vector bus for a processor core. A single active enabled line is reported with its own vector, counted up from a fixed base. When two or more enabled lines are active at once, the block reports one shared "several pending" vector. Software then reads the masked word and decides which line to serve first.

A small 32-bit register window gives software access to the mask, the live pending and masked words, and two plain storage words for non-maskable and debug status. These two words have no logic behind them. Only full-word accesses act on the registers. Narrow accesses read as zero and change nothing. An access outside the window returns zero and raises a one-cycle error flag.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Input line n (n = 1..30) drives bit n-1 of the pending word. The pending word is registered on each clock edge and follows the line level, so a bit clears when its line drops.
- R2: The masked word is always the pending word ANDed with the mask. Software reads it at offset 0x08.
- R3: When exactly one masked bit is set, at position i, `irqReq` is 1 and `irqVector` is 0x31 + i.
- R4: When two or more masked bits are set, `irqReq` is 1 and `irqVector` is 0x30.
- R5: When no masked bit is set, `irqReq` is 0 and `irqVector` is 0.
- R6: The word offsets are as follows. 0x00 is the mask (read/write, 30 valid bits, upper bits read 0). 0x04 is the pending word and 0x08 is the masked word. 0x0C is the NMI storage word and 0x10 is the debug storage word; both are full 32-bit read/write words. Read data appears on `busRdata` in the cycle after the read strobe.
- R7: `busSize` encodes 2'b00 byte, 2'b01 halfword, 2'b10 word. Byte and halfword reads return 0, and byte and halfword writes change no register.
- R8: Writes to offsets 0x04 and 0x08 have no effect.
- R9: A full-word mask write changes `irqReq` and `irqVector` from the clock edge that takes the write. No pending level is lost.
- R10: A read or write at any address other than the five offsets returns 0. It raises `busErr` for exactly the one cycle after the access and writes nothing.
- R11: Reset (active-low, asynchronous) clears the mask, the pending word and both storage words, holds `irqReq` at 0 and holds `irqVector` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | 30 | Level-sensitive interrupt inputs, line n on bit n-1 |
| busAddr | input | 8 | Byte offset into the register window |
| busSize | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after the read strobe |
| busErr | output | 1 | One-cycle error flag for an out-of-window access |
| irqReq | output | 1 | Interrupt request to the core |
| irqVector | output | 8 | Vector number presented to the core |

## Verification
The assertions assume that `busRd` and `busWr` are never high in the same cycle, and that `irqLines` is synchronous to `clk`. Under those assumptions the pending word can be compared one-for-one with the previous cycle's line levels. The bench drives every input on the falling edge, issues one bus operation at a time with exactly one strobe, and changes the interrupt lines only between bus operations. No access straddles an edge, so each sampled value has a single expected result.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int unsigned BUS_W = 32;

  localparam logic [1:0] SIZE_BYTE = 2'b00;
  localparam logic [1:0] SIZE_HALF = 2'b01;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  localparam logic [7:0] OFF_MASK   = 8'h00;
  localparam logic [7:0] OFF_PEND   = 8'h04;
  localparam logic [7:0] OFF_MASKED = 8'h08;
  localparam logic [7:0] OFF_NMI    = 8'h0C;
  localparam logic [7:0] OFF_DBG    = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_PEND,
    SEL_MASKED,
    SEL_NMI,
    SEL_DBG
  } regSel_t;

  typedef struct packed {
    logic    wrMask;
    logic    wrNmi;
    logic    wrDbg;
    logic    rdEn;
    regSel_t rdSel;
  } strobe_t;

endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic              busRd,
  input  logic              busWr,
  output strobe_t           strb,
  output logic              busErr
);

  logic    wordAcc;
  logic    anyAcc;
  logic    inWin;
  logic    badAcc;
  regSel_t hitSel;
  logic    errQ;

  assign wordAcc = (busSize == SIZE_WORD);
  assign anyAcc  = busRd | busWr;

  always_comb begin
    hitSel = SEL_NONE;
    inWin  = 1'b1;
    case (busAddr)
      ADDR_W'(OFF_MASK):   hitSel = SEL_MASK;
      ADDR_W'(OFF_PEND):   hitSel = SEL_PEND;
      ADDR_W'(OFF_MASKED): hitSel = SEL_MASKED;
      ADDR_W'(OFF_NMI):    hitSel = SEL_NMI;
      ADDR_W'(OFF_DBG):    hitSel = SEL_DBG;
      default:             inWin  = 1'b0;
    endcase
  end

  assign badAcc = anyAcc & ~inWin;

  always_comb begin
    strb        = '0;
    strb.rdSel  = SEL_NONE;
    strb.rdEn   = busRd;
    if (busRd && wordAcc) strb.rdSel = hitSel;
    if (busWr && wordAcc) begin
      strb.wrMask = (hitSel == SEL_MASK);
      strb.wrNmi  = (hitSel == SEL_NMI);
      strb.wrDbg  = (hitSel == SEL_DBG);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= badAcc;
  end

  assign busErr = errQ;

  // R10: an error flag is only ever the echo of an out-of-window access
  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(anyAcc) && !$past(inWin));

  // R6: at most one storage word is written per cycle
  assert_one_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMask, strb.wrNmi, strb.wrDbg}));

  // R7: narrow writes never reach a register
  assert_narrow_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !wordAcc) |-> !(strb.wrMask || strb.wrNmi || strb.wrDbg));

endmodule

// File: rtl/vic_vec_enc.sv
module vic_vec_enc #(
  parameter int unsigned  NUM_LINES = 30,
  parameter int unsigned  VEC_W     = 8,
  parameter logic [7:0]   VEC_BASE  = 8'h30
) (
  input  logic [NUM_LINES-1:0] maskedVec,
  output logic                 req,
  output logic [VEC_W-1:0]     vector
);

  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic             anySet;
  logic             multiSet;
  logic [IDX_W-1:0] lineIdx;

  assign anySet   = |maskedVec;
  assign multiSet = |(maskedVec & (maskedVec - NUM_LINES'(1)));

  // Each index bit is the OR of the masked bits whose position has it set;
  // exact whenever only one masked bit is active.
  for (genvar b = 0; b < IDX_W; b++) begin : g_idxBit
    logic [NUM_LINES-1:0] sel;
    for (genvar p = 0; p < NUM_LINES; p++) begin : g_pos
      assign sel[p] = ((p >> b) & 1) != 0;
    end
    assign lineIdx[b] = |(maskedVec & sel);
  end

  always_comb begin
    if (!anySet)       vector = '0;
    else if (multiSet) vector = VEC_W'(VEC_BASE);
    else               vector = VEC_W'(VEC_BASE) + VEC_W'(1) + VEC_W'(lineIdx);
  end

  assign req = anySet;

endmodule

// File: rtl/vic_dp.sv
module vic_dp
  import vic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 30,
  parameter int unsigned VEC_W     = 8,
  parameter logic [7:0]  VEC_BASE  = 8'h30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  strobe_t              strb,
  input  logic [BUS_W-1:0]     busWdata,
  output logic [BUS_W-1:0]     busRdata,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     irqVector
);

  logic [NUM_LINES-1:0] pendQ;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] maskedW;
  logic [BUS_W-1:0]     nmiQ;
  logic [BUS_W-1:0]     dbgQ;
  logic [BUS_W-1:0]     rdMux;
  logic [BUS_W-1:0]     rdataQ;
  logic                 armedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
      nmiQ  <= '0;
      dbgQ  <= '0;
    end else begin
      pendQ <= irqLines;
      if (strb.wrMask) maskQ <= busWdata[NUM_LINES-1:0];
      if (strb.wrNmi)  nmiQ  <= busWdata;
      if (strb.wrDbg)  dbgQ  <= busWdata;
    end
  end

  assign maskedW = pendQ & maskQ;

  always_comb begin
    case (strb.rdSel)
      SEL_MASK:   rdMux = BUS_W'(maskQ);
      SEL_PEND:   rdMux = BUS_W'(pendQ);
      SEL_MASKED: rdMux = BUS_W'(maskedW);
      SEL_NMI:    rdMux = nmiQ;
      SEL_DBG:    rdMux = dbgQ;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdataQ <= '0;
    else if (strb.rdEn) rdataQ <= rdMux;
  end

  assign busRdata = rdataQ;

  vic_vec_enc #(
    .NUM_LINES (NUM_LINES),
    .VEC_W     (VEC_W),
    .VEC_BASE  (VEC_BASE)
  ) u_enc (
    .maskedVec (maskedW),
    .req       (irqReq),
    .vector    (irqVector)
  );

  // armedQ marks that the previous edge was outside reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armedQ <= 1'b0;
    else       armedQ <= 1'b1;
  end

  // R1: pending word tracks the line levels one edge later
  assert_pend_follow_R1: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> pendQ == $past(irqLines));

  // R9: a word mask write lands in the mask at its edge
  assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMask |=> maskQ == $past(busWdata[NUM_LINES-1:0]));

  // R4: several enabled lines give the shared vector
  assert_multi_shared_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(pendQ & maskQ) > 1) |-> (irqReq && irqVector == VEC_W'(VEC_BASE)));

  // R3: a request always carries a vector inside the legal range
  assert_vec_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVector >= VEC_W'(VEC_BASE) &&
                irqVector <= VEC_W'(VEC_BASE) + VEC_W'(NUM_LINES)));

  // R5: no request means a zero vector
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> irqVector == '0);

  // R8: pending word is owned by the lines, not by bus writes
  assert_pend_ro_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && $past(irqLines) == '0) |-> pendQ == '0);

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 30,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned VEC_W     = 8,
  parameter logic [7:0]  VEC_BASE  = 8'h30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [1:0]           busSize,
  input  logic                 busRd,
  input  logic                 busWr,
  input  logic [BUS_W-1:0]     busWdata,
  output logic [BUS_W-1:0]     busRdata,
  output logic                 busErr,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     irqVector
);

  strobe_t strb;

  vic_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busSize (busSize),
    .busRd   (busRd),
    .busWr   (busWr),
    .strb    (strb),
    .busErr  (busErr)
  );

  vic_dp #(
    .NUM_LINES (NUM_LINES),
    .VEC_W     (VEC_W),
    .VEC_BASE  (VEC_BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqLines  (irqLines),
    .strb      (strb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .irqReq    (irqReq),
    .irqVector (irqVector)
  );

endmodule

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [29:0] irqLines = '0;
  logic [7:0]  busAddr = '0;
  logic [1:0]  busSize = 2'b10;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic        irqReq;
  logic [7:0]  irqVector;

  int nChecks = 0;
  int nFail   = 0;
  logic done  = 1'b0;

  always #4 clk = ~clk;

  vec_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .irqLines(irqLines),
    .busAddr(busAddr), .busSize(busSize), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .irqReq(irqReq), .irqVector(irqVector)
  );

  localparam int NV = 9;
  localparam logic [29:0] T_LINES [NV] = '{
    30'h0000_0000, 30'h0000_0001, 30'h2000_0000, 30'h0000_0005, 30'h0000_0005,
    30'h3FFF_FFFF, 30'h0000_0100, 30'h3FFF_FFFF, 30'h0001_0000 };
  localparam logic [29:0] T_MASK [NV] = '{
    30'h3FFF_FFFF, 30'h3FFF_FFFF, 30'h3FFF_FFFF, 30'h3FFF_FFFF, 30'h0000_0004,
    30'h0000_0000, 30'h0000_0100, 30'h2000_0001, 30'h0001_FFFF };
  localparam logic [7:0] T_VEC [NV] = '{
    8'h00, 8'h31, 8'h4E, 8'h30, 8'h33, 8'h00, 8'h39, 8'h30, 8'h41 };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic busOp(input logic rd, input logic wr, input logic [7:0] addr,
                       input logic [1:0] size, input logic [31:0] data,
                       output logic [31:0] rdata);
    @(negedge clk);
    busRd = rd; busWr = wr; busAddr = addr; busSize = size; busWdata = data;
    @(posedge clk); #1;
    rdata = busRdata;
    busRd = 1'b0; busWr = 1'b0;
  endtask

  task automatic wrWord(input logic [7:0] addr, input logic [31:0] data);
    logic [31:0] d;
    busOp(1'b0, 1'b1, addr, 2'b10, data, d);
  endtask

  task automatic rdWord(input logic [7:0] addr, output logic [31:0] data);
    busOp(1'b1, 1'b0, addr, 2'b10, 32'h0, data);
  endtask

  task automatic setLines(input logic [29:0] v);
    @(negedge clk);
    irqLines = v;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    string tag;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;

    // R11: reset state
    check("R11", "req after reset", {31'b0, irqReq}, 32'h0);
    check("R11", "vector after reset", {24'b0, irqVector}, 32'h0);
    rdWord(8'h00, rd); check("R11", "mask after reset", rd, 32'h0);
    rdWord(8'h0C, rd); check("R11", "nmi after reset", rd, 32'h0);
    rdWord(8'h10, rd); check("R11", "dbg after reset", rd, 32'h0);

    // Table walk: R2, R3, R4, R5
    for (int i = 0; i < NV; i++) begin
      wrWord(8'h00, {2'b00, T_MASK[i]});
      setLines(T_LINES[i]);
      tag = (T_VEC[i] == 8'h00) ? "R5" : (T_VEC[i] == 8'h30) ? "R4" : "R3";
      check(tag, "req", {31'b0, irqReq}, {31'b0, T_VEC[i] != 8'h00});
      check(tag, "vector", {24'b0, irqVector}, {24'b0, T_VEC[i]});
      rdWord(8'h08, rd); check("R2", "masked word", rd, {2'b00, T_LINES[i] & T_MASK[i]});
      rdWord(8'h04, rd); check("R1", "pending word", rd, {2'b00, T_LINES[i]});
    end

    // R1: level following, bit drops with its line
    wrWord(8'h00, 32'h3FFF_FFFF);
    setLines(30'h0000_0008);
    rdWord(8'h04, rd); check("R1", "pending line 4", rd, 32'h0000_0008);
    check("R1", "vector line 4", {24'b0, irqVector}, 32'h34);
    setLines(30'h0);
    check("R1", "req after drop", {31'b0, irqReq}, 32'h0);
    rdWord(8'h04, rd); check("R1", "pending after drop", rd, 32'h0);

    // R9: mask write acts at its own edge
    wrWord(8'h00, 32'h0);
    setLines(30'h0000_0010);
    check("R9", "req masked off", {31'b0, irqReq}, 32'h0);
    wrWord(8'h00, 32'h0000_0010);
    check("R9", "req after mask write", {31'b0, irqReq}, 32'h1);
    check("R9", "vector after mask write", {24'b0, irqVector}, 32'h35);

    // R6: upper mask bits read zero, storage words read back
    wrWord(8'h00, 32'hFFFF_FFFF);
    rdWord(8'h00, rd); check("R6", "mask width", rd, 32'h3FFF_FFFF);
    wrWord(8'h0C, 32'hA5A5_5A5A);
    wrWord(8'h10, 32'h1234_5678);
    rdWord(8'h0C, rd); check("R6", "nmi word", rd, 32'hA5A5_5A5A);
    rdWord(8'h10, rd); check("R6", "dbg word", rd, 32'h1234_5678);

    // R7: narrow accesses
    busOp(1'b0, 1'b1, 8'h00, 2'b00, 32'h0, rd);
    busOp(1'b0, 1'b1, 8'h0C, 2'b01, 32'h0, rd);
    rdWord(8'h00, rd); check("R7", "mask after narrow write", rd, 32'h3FFF_FFFF);
    rdWord(8'h0C, rd); check("R7", "nmi after narrow write", rd, 32'hA5A5_5A5A);
    busOp(1'b1, 1'b0, 8'h10, 2'b00, 32'h0, rd); check("R7", "byte read", rd, 32'h0);
    busOp(1'b1, 1'b0, 8'h00, 2'b01, 32'h0, rd); check("R7", "half read", rd, 32'h0);

    // R8: writes to pending and masked words ignored
    setLines(30'h0);
    wrWord(8'h04, 32'hFFFF_FFFF);
    wrWord(8'h08, 32'hFFFF_FFFF);
    check("R8", "req after ro writes", {31'b0, irqReq}, 32'h0);
    rdWord(8'h04, rd); check("R8", "pending after write", rd, 32'h0);
    rdWord(8'h08, rd); check("R8", "masked after write", rd, 32'h0);

    // R10: out-of-window accesses
    rdWord(8'h14, rd);
    check("R10", "err after bad read", {31'b0, busErr}, 32'h1);
    check("R10", "bad read data", rd, 32'h0);
    @(posedge clk); #1;
    check("R10", "err one cycle", {31'b0, busErr}, 32'h0);
    wrWord(8'h40, 32'h0);
    check("R10", "err after bad write", {31'b0, busErr}, 32'h1);
    rdWord(8'h00, rd); check("R10", "mask after bad write", rd, 32'h3FFF_FFFF);
    check("R10", "err cleared by good read", {31'b0, busErr}, 32'h0);

    // R11: reset mid-run with an active request
    setLines(30'h0000_0002);
    check("R11", "req before reset", {31'b0, irqReq}, 32'h1);
    @(negedge clk); rstN = 1'b0; #1;
    check("R11", "req in reset", {31'b0, irqReq}, 32'h0);
    check("R11", "vector in reset", {24'b0, irqVector}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    rdWord(8'h00, rd); check("R11", "mask cleared", rd, 32'h0);
    rdWord(8'h10, rd); check("R11", "dbg cleared", rd, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule